// File: doc/BRIEF.md
# Address-Masked GPIO Port with Commit Lock

This block is an eight-pin general-purpose I/O port with a small memory-mapped register interface. The data register is reached through a window of 256 word addresses. Address bits [9:2] of an access into that window act as a per-pin mask. Software can therefore set or clear single pins with one store, with no read-modify-write. The same mask applies to loads, so software can sample a chosen subset of pins.

Each pin has a direction bit and a pull-down enable bit. These two configuration registers are guarded by a per-pin commit mask. The commit mask itself can only be changed after a key has been written to a lock register. The pads are modelled as separate vectors:

- an output value and an output enable, both driven by the block;
- an incoming level, and a flag that says whether something outside is actually driving the pin.

The incoming level passes through a two-flop synchronizer before the block reads it.

Every access is a single-cycle request on `bus_en`. `bus_ready` answers one cycle later, and `bus_rdata` is valid with it.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to byte offset A with A below 0x400 updates the output latch only for pins whose bit in A[9:2] is 1. Pin i uses bit A[2+i]. All other latches keep their value.
- R2: At offset 0x3FC every mask bit is set. A write there loads all eight latches from write data bits [7:0], and a read there returns all eight pins.
- R3: A data-window read returns 0 in every bit [7:0] whose mask bit is 0, and returns 0 in bits [31:8].
- R4: In a data-window read, a pin whose direction bit is 1 returns its output latch. A pin whose direction bit is 0 returns its resolved input after two synchronizer flops. A read request issued two or more clock edges after the pad changes returns the new level.
- R5: The direction register sits at offset 0x400 (1 = output). `pad_oe` equals the direction register, and `pad_out` equals the output latch.
- R6: The pull-down register sits at offset 0x514. An input pin with `pad_ext_en` = 0 resolves to 0 when its pull-down bit is 1, and to `pad_in` when the bit is 0. When `pad_ext_en` = 1, the pin resolves to `pad_in` regardless of the pull-down bit.
- R7: The lock register sits at offset 0x520. Writing 0x4C4F434B unlocks the port, and writing any other value locks it. A read returns 1 while the port is locked and 0 while it is unlocked.
- R8: The commit register sits at offset 0x524. It changes only when written while the port is unlocked. A write to the direction or pull-down register changes only the bits whose commit bit is 1.
- R9: After reset, direction, pull-down and output latches are 0, commit is 0xFF, and the port is locked.
- R10: `bus_ready` is 1 exactly one cycle after a request. Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completed (one cycle after bus_en) |
| pad_in | input | 8 | Level seen on each pad |
| pad_ext_en | input | 8 | 1 where an outside source drives the pad |
| pad_out | output | 8 | Output latch value per pin |
| pad_oe | output | 8 | Output enable per pin |

## Verification
Two things can meet in one data-window read: mixed-direction pins where some bits come from output latches and others from synchronized inputs, and the address mask that clears unselected bits. The bench sweeps all 256 masks with half the pins as outputs. Before each read it applies a fresh pad pattern, and it compares every result with the arithmetic combination of the latch, the pad value, the direction and the mask. A second collision is a commit-register write arriving while the port is locked. This is provoked directly, and it is judged by reading back commit, direction and pull-down after the write.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [11:0] OFS_DIR    = 12'h400;
  localparam logic [11:0] OFS_PULLDN = 12'h514;
  localparam logic [11:0] OFS_LOCK   = 12'h520;
  localparam logic [11:0] OFS_COMMIT = 12'h524;
  localparam logic [31:0] UNLOCK_KEY = 32'h4C4F434B;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_PULLDN,
    SEL_LOCK,
    SEL_COMMIT
  } reg_sel_e;
endpackage

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] async_i,
  output logic [PINS-1:0] sync_o
);
  logic [PINS-1:0] stage1_q;
  logic [PINS-1:0] stage2_q;

  for (genvar i = 0; i < PINS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= async_i[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign sync_o = stage2_q;

  // R4: the synchronized value lags the input by exactly two edges
  a_r4_two_flop_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst, 2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/gpio_mask_cfg.sv
module gpio_mask_cfg
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dir,
  input  logic             wr_pulldn,
  input  logic             wr_lock,
  input  logic             wr_commit,
  input  logic [BUS_W-1:0] wdata,
  output logic [PINS-1:0]  dir_o,
  output logic [PINS-1:0]  pulldn_o,
  output logic             locked_o,
  output logic [PINS-1:0]  commit_o
);
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] pulldn_q;
  logic [PINS-1:0] commit_q;
  logic            locked_q;
  logic [PINS-1:0] wpins;

  assign wpins = wdata[PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= '0;
      pulldn_q <= '0;
      commit_q <= '1;
      locked_q <= 1'b1;
    end else begin
      if (wr_dir)
        dir_q <= (dir_q & ~commit_q) | (wpins & commit_q);
      if (wr_pulldn)
        pulldn_q <= (pulldn_q & ~commit_q) | (wpins & commit_q);
      if (wr_lock)
        locked_q <= (wdata != UNLOCK_KEY);
      if (wr_commit && !locked_q)
        commit_q <= wpins;
    end
  end

  assign dir_o    = dir_q;
  assign pulldn_o = pulldn_q;
  assign locked_o = locked_q;
  assign commit_o = commit_q;

  // R8: commit cannot move while locked
  a_r8_commit_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && locked_q) |=> $stable(commit_q));
  // R8: uncommitted direction bits hold
  a_r8_dir_gated: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> (((dir_q ^ $past(dir_q)) & ~$past(commit_q)) == '0));
  // R8: uncommitted pull-down bits hold
  a_r8_pulldn_gated: assert property (@(posedge clk) disable iff (rst)
    wr_pulldn |=> (((pulldn_q ^ $past(pulldn_q)) & ~$past(commit_q)) == '0));
  // R7: the key unlocks
  a_r7_key_unlocks: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && wdata == UNLOCK_KEY) |=> !locked_q);
  // R7: other values relock
  a_r7_other_locks: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && wdata != UNLOCK_KEY) |=> locked_q);
endmodule

// File: rtl/gpio_mask_data.sv
module gpio_mask_data #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PINS-1:0] mask,
  input  logic [PINS-1:0] wpins,
  output logic [PINS-1:0] out_o
);
  logic [PINS-1:0] out_q;

  for (genvar i = 0; i < PINS; i++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst)
        out_q[i] <= 1'b0;
      else if (wr_en && mask[i])
        out_q[i] <= wpins[i];
    end
  end

  assign out_o = out_q;

  // R1: unmasked latches keep their value across a data write
  a_r1_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0));
  // R1: masked latches take the written value
  a_r1_masked_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((out_q & $past(mask)) == ($past(wpins) & $past(mask))));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PINS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ready,
  input  logic [PINS-1:0]   pad_in,
  input  logic [PINS-1:0]   pad_ext_en,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = MASK_LO + PINS - 1;
  localparam int unsigned WIN_TOP = MASK_HI + 1;

  reg_sel_e        sel;
  logic [PINS-1:0] mask;
  logic [PINS-1:0] dir, pulldn, commit, out_latch;
  logic [PINS-1:0] pin_raw, pin_sync, data_rd;
  logic            locked;
  logic [BUS_W-1:0] rd_next;
  logic            wr_req, rd_data_req;
  logic [1:0]      unused_lsb;

  assign unused_lsb = bus_addr[1:0];
  assign mask       = bus_addr[MASK_HI:MASK_LO];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    return a[ADDR_W-1:2] == ADDR_W'(ofs) >> 2;
  endfunction

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr[ADDR_W-1:WIN_TOP] == '0) sel = SEL_DATA;
    else if (hit(bus_addr, OFS_DIR))      sel = SEL_DIR;
    else if (hit(bus_addr, OFS_PULLDN))   sel = SEL_PULLDN;
    else if (hit(bus_addr, OFS_LOCK))     sel = SEL_LOCK;
    else if (hit(bus_addr, OFS_COMMIT))   sel = SEL_COMMIT;
  end

  assign wr_req      = bus_en && bus_we;
  assign rd_data_req = bus_en && !bus_we && (sel == SEL_DATA);

  gpio_mask_cfg #(.PINS(PINS)) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .wr_dir    (wr_req && sel == SEL_DIR),
    .wr_pulldn (wr_req && sel == SEL_PULLDN),
    .wr_lock   (wr_req && sel == SEL_LOCK),
    .wr_commit (wr_req && sel == SEL_COMMIT),
    .wdata     (bus_wdata),
    .dir_o     (dir),
    .pulldn_o  (pulldn),
    .locked_o  (locked),
    .commit_o  (commit)
  );

  gpio_mask_data #(.PINS(PINS)) data_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_req && sel == SEL_DATA),
    .mask  (mask),
    .wpins (bus_wdata[PINS-1:0]),
    .out_o (out_latch)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pad
    assign pin_raw[i] = pad_ext_en[i] ? pad_in[i] : (pulldn[i] ? 1'b0 : pad_in[i]);
  end

  gpio_mask_sync #(.PINS(PINS)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .async_i(pin_raw),
    .sync_o (pin_sync)
  );

  assign data_rd = ((out_latch & dir) | (pin_sync & ~dir)) & mask;

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DATA:   rd_next[PINS-1:0] = data_rd;
      SEL_DIR:    rd_next[PINS-1:0] = dir;
      SEL_PULLDN: rd_next[PINS-1:0] = pulldn;
      SEL_LOCK:   rd_next[0]        = locked;
      SEL_COMMIT: rd_next[PINS-1:0] = commit;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_en;
      bus_rdata <= (bus_en && !bus_we) ? rd_next : '0;
    end
  end

  assign pad_out = out_latch;
  assign pad_oe  = dir;

  // R3: unselected data bits read zero
  a_r3_mask_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data_req |=> (((bus_rdata[PINS-1:0] & ~$past(mask)) == '0) &&
                     (bus_rdata[BUS_W-1:PINS] == '0)));
  // R10: every request is answered on the next cycle
  a_r10_ready_follows: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> bus_ready);
  // R10: no answer without a request
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> !bus_ready);
endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [7:0]  pad_in = '0, pad_ext_en = '0;
  logic [7:0]  pad_out, pad_oe;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0]  exp_out = 8'h00;
  logic [31:0] rd;

  always #2 clk = ~clk;

  gpio_mask_port dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pad_in(pad_in), .pad_ext_en(pad_ext_en),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state, R10 idle ready
    chk("R10 idle ready", {31'b0, bus_ready}, 32'd0);
    chk("R9 pad_oe", {24'b0, pad_oe}, 32'h0);
    chk("R9 pad_out", {24'b0, pad_out}, 32'h0);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 12'h520;
    @(negedge clk);
    bus_en = 1'b0;
    chk("R10 ready after request", {31'b0, bus_ready}, 32'd1);
    chk("R9 R7 lock reads locked", bus_rdata, 32'd1);
    rdreg(12'h524, rd); chk("R9 commit", rd, 32'hFF);
    rdreg(12'h400, rd); chk("R9 dir", rd, 32'h0);
    rdreg(12'h514, rd); chk("R9 pulldown", rd, 32'h0);
    rdreg(12'h3FC, rd); chk("R9 data", rd, 32'h0);

    // R6 pull-down on undriven inputs
    wr(12'h514, 32'h5A);
    pad_in = 8'hFF; pad_ext_en = 8'h00;
    repeat (2) @(negedge clk);
    rdreg(12'h3FC, rd); chk("R6 pull-down undriven", rd, 32'hA5);
    pad_ext_en = 8'hFF;
    repeat (2) @(negedge clk);
    rdreg(12'h3FC, rd); chk("R6 driver overrides pull-down", rd, 32'hFF);

    // R5 direction to outputs
    wr(12'h400, 32'hFF);
    chk("R5 pad_oe follows dir", {24'b0, pad_oe}, 32'hFF);

    // R2 full write
    wr(12'h3FC, 32'h0000_00C3); exp_out = 8'hC3;
    chk("R2 full-mask write", {24'b0, pad_out}, {24'b0, exp_out});
    rdreg(12'h3FC, rd); chk("R2 R4 full read of outputs", rd, {24'b0, exp_out});

    // R1 exhaustive mask sweep on writes
    for (int m = 0; m < 256; m++) begin
      logic [7:0] v;
      v = 8'((m * 37 + 11) & 8'hFF);
      wr(12'(m << 2), {24'hABCDEF, v});
      exp_out = (exp_out & ~8'(m)) | (v & 8'(m));
      chk("R1 masked write", {24'b0, pad_out}, {24'b0, exp_out});
    end

    // R3 R4 mixed-direction read sweep
    wr(12'h400, 32'h0F);
    chk("R5 pad_oe mixed", {24'b0, pad_oe}, 32'h0F);
    for (int m = 0; m < 256; m++) begin
      logic [7:0] p, e;
      p = 8'((m * 53) ^ 8'hA5);
      pad_in = p;
      repeat (2) @(negedge clk);
      rdreg(12'(m << 2), rd);
      e = ((exp_out & 8'h0F) | (p & 8'hF0)) & 8'(m);
      chk("R3 R4 masked mixed read", rd, {24'b0, e});
    end

    // R7 R8 lock and commit
    wr(12'h524, 32'h0F);
    rdreg(12'h524, rd); chk("R8 commit ignored while locked", rd, 32'hFF);
    wr(12'h520, 32'h1234_5678);
    rdreg(12'h520, rd); chk("R7 wrong key stays locked", rd, 32'd1);
    wr(12'h520, 32'h4C4F434B);
    rdreg(12'h520, rd); chk("R7 key unlocks", rd, 32'd0);
    wr(12'h524, 32'h0F);
    rdreg(12'h524, rd); chk("R8 commit written unlocked", rd, 32'h0F);
    wr(12'h400, 32'hF0);
    rdreg(12'h400, rd); chk("R8 dir gated by commit", rd, 32'h00);
    chk("R8 pad_oe gated", {24'b0, pad_oe}, 32'h00);
    wr(12'h400, 32'hFF);
    rdreg(12'h400, rd); chk("R8 dir committed bits", rd, 32'h0F);
    wr(12'h514, 32'h00);
    rdreg(12'h514, rd); chk("R8 pull-down gated", rd, 32'h50);
    wr(12'h520, 32'h0);
    rdreg(12'h520, rd); chk("R7 relock", rd, 32'd1);
    wr(12'h524, 32'hFF);
    rdreg(12'h524, rd); chk("R8 commit frozen after relock", rd, 32'h0F);

    // R10 unmapped
    wr(12'h600, 32'hFFFF_FFFF);
    rdreg(12'h600, rd); chk("R10 unmapped reads zero", rd, 32'h0);
    rdreg(12'h400, rd); chk("R10 unmapped write no effect", rd, 32'h0F);
    chk("R10 latches untouched", {24'b0, pad_out}, {24'b0, exp_out});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule